// File: doc/BRIEF.md
# Multi-Channel Thermal Alert Monitor

This block compares four temperature channels against three alert levels per channel and raises one combined interrupt when a crossing happens. Each channel delivers a 10-bit ADC code in which a hotter reading gives a smaller code. All four codes arrive together on one parallel bus, qualified by a single strobe. On every strobe the block updates a hot/cold state for each channel and each level. When that state changes in a direction that is reported, the block latches a pending flag.

Levels 0 and 1 are warning levels. Each has a 10-bit threshold, a 4-bit hysteresis, an enable bit and a throttle-enable bit, and both crossing directions are reported. Level 2 is the critical level. Its 8-bit threshold is widened to code scale in one of two ways, picked by an input pin, and only the hot crossing is reported. Software uses a byte-wide register port to program the thresholds, read the direction status, acknowledge pending flags by writing ones, and mask individual flags or the whole interrupt.

Top module: `thermal_watch`

## Requirements
- R1: After reset the pending registers 0x00 and 0x01 read 0x00, the warning mask 0x02 reads 0xFF, the critical mask 0x03 reads 0x00, the gate register 0x04 reads 0x00, every status register reads 0x00, and irq_out is low.
- R2: Channel c, warning level L (0 or 1), has its config byte at 0x10+4c+2L and its threshold low byte at the next address. The config byte holds threshold bits 9:8 in bits 1:0, hysteresis in bits 5:2, the alert enable in bit 6 and the throttle enable in bit 7. The critical byte of channel c is at 0x20+c. All of these read back what was written.
- R3: When an enabled warning level is cold and a strobed code is less than or equal to its threshold, the level turns hot at that clock edge. Its status bit is set (0x05 for level 0, 0x06 for level 1, bit c). Its pending bit is set in 0x00: bit c for level 0, bit 4+c for level 1.
- R4: When a hot warning level is strobed with a code greater than threshold plus hysteresis, it turns cold, its status bit clears and its pending bit is set. A code above the threshold but no greater than threshold plus hysteresis changes nothing.
- R5: A warning level whose enable bit is 0 changes neither its status bit nor its pending bit, whatever code it receives.
- R6: The critical level of channel c compares against {0, byte, 0} when crit_mode is 0 and against {byte, 00} when crit_mode is 1. A code less than or equal to that value sets status bit c of 0x07 and pending bit c of 0x01. Rising above it again clears the status bit and sets no pending bit.
- R7: Writing a one to a pending bit in 0x00 or 0x01 clears that bit, and writing a zero leaves it unchanged. A new event in the same cycle as the clear takes priority. Bits 7:4 of 0x01 always read zero.
- R8: irq_out is high when any pending bit is set while its mask bit is 0, and bit 0 of 0x04 is 0. The mask bits are laid out like the pending bits: 0x02 for the warning levels, 0x03 for the critical level. A masked event is still latched as pending.
- R9: hot_throttle[c] is high exactly while warning level 0 or 1 of channel c is hot with its throttle enable bit set.
- R10: Codes presented while sample_valid is low have no effect on any status or pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Strobe qualifying sample_codes |
| sample_codes | input | NUM_CH*CODE_W | Channel c code in bits [c*CODE_W +: CODE_W] |
| crit_mode | input | 1 | Critical threshold widening: 0 = bits 8:1, 1 = bits 9:2 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| irq_out | output | 1 | Combined thermal interrupt |
| hot_throttle | output | NUM_CH | Per-channel throttle request |

## Verification
The directed cases first strobe codes above, exactly at, and inside the hysteresis band of a threshold. This separates an inclusive compare from an exclusive one, and it shows whether hysteresis is added to the release point rather than to the trip point. A disabled channel and a channel fed changing codes with the strobe low are used to show that the enable and the strobe each gate the state. The same critical byte is tested under both widening modes: a code of 200 trips in one mode and not in the other, which checks the bit alignment. Mask, gate and write-one-to-clear cases, run with two events pending at once, check that clearing and masking act on the individual bits they target.

// File: rtl/thw_pkg.sv
package thw_pkg;
   localparam int unsigned LVL_NUM  = 3;
   localparam int unsigned WARN_NUM = 2;
   localparam int unsigned LVL_CRIT = 2;

   localparam logic [7:0] A_PEND_WARN = 8'h00;
   localparam logic [7:0] A_PEND_CRIT = 8'h01;
   localparam logic [7:0] A_MASK_WARN = 8'h02;
   localparam logic [7:0] A_MASK_CRIT = 8'h03;
   localparam logic [7:0] A_GATE      = 8'h04;
   localparam logic [7:0] A_STAT_BASE = 8'h05;
   localparam logic [7:0] A_WARN_BASE = 8'h10;
   localparam logic [7:0] A_CRIT_BASE = 8'h20;

   // address of the config byte of one warning level; the low byte follows
   function automatic logic [7:0] warn_cfg_addr(int unsigned lvl, int unsigned ch);
      return A_WARN_BASE + 8'(4 * ch + 2 * lvl);
   endfunction

   // bit position of a pending/mask flag inside its byte
   function automatic int unsigned flag_slot(int unsigned lvl, int unsigned ch);
      return (lvl == 1) ? 4 + ch : ch;
   endfunction
endpackage

// File: rtl/thw_det.sv
module thw_det #(
   parameter int unsigned CODE_W   = 10,
   parameter int unsigned HYST_W   = 4,
   parameter bit          BOTH_DIR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic              enable,
   input  logic [CODE_W-1:0] code,
   input  logic [CODE_W-1:0] thr,
   input  logic [HYST_W-1:0] hyst,
   output logic              hot,
   output logic              evt
);
   localparam int unsigned EXT_W = CODE_W + 1;

   logic [EXT_W-1:0] release_lvl;
   logic             go_hot, go_cold, upd;

   assign release_lvl = {1'b0, thr} + EXT_W'(hyst);
   assign go_hot      = !hot && (code <= thr);
   assign go_cold     = hot && ({1'b0, code} > release_lvl);
   assign upd         = smp_valid && enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                hot <= 1'b0;
      else if (upd && go_hot)    hot <= 1'b1;
      else if (upd && go_cold)   hot <= 1'b0;
   end

   generate
      if (BOTH_DIR) begin : g_both
         assign evt = upd && (go_hot || go_cold);
      end else begin : g_hot_only
         assign evt = upd && go_hot;
      end
   endgenerate
endmodule

// File: rtl/thw_regs.sv
module thw_regs
   import thw_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CODE_W = 10,
   parameter int unsigned HYST_W = 4
) (
   input  logic                                           clk,
   input  logic                                           rst_n,
   input  logic                                           reg_we,
   input  logic [7:0]                                     reg_addr,
   input  logic [7:0]                                     reg_wdata,
   input  logic [LVL_NUM-1:0][NUM_CH-1:0]                 evt,
   input  logic [LVL_NUM-1:0][NUM_CH-1:0]                 hot,
   output logic [7:0]                                     reg_rdata,
   output logic [WARN_NUM-1:0][NUM_CH-1:0][CODE_W-1:0]    warn_thr,
   output logic [WARN_NUM-1:0][NUM_CH-1:0][HYST_W-1:0]    warn_hyst,
   output logic [WARN_NUM-1:0][NUM_CH-1:0]                warn_en,
   output logic [WARN_NUM-1:0][NUM_CH-1:0]                warn_thrtl,
   output logic [NUM_CH-1:0][7:0]                         crit_thr,
   output logic [LVL_NUM-1:0][NUM_CH-1:0]                 pend,
   output logic                                           gate,
   output logic                                           irq_out
);
   localparam int unsigned HI_THR_W = CODE_W - 8;

   logic [WARN_NUM-1:0][NUM_CH-1:0][7:0] cfg_q, low_q;
   logic [NUM_CH-1:0][7:0]               crit_q;
   logic [LVL_NUM-1:0][NUM_CH-1:0]       msk_q, pend_q, pend_clr;
   logic                                 gate_q;

   always_comb begin
      for (int l = 0; l < WARN_NUM; l++) begin
         for (int c = 0; c < NUM_CH; c++) begin
            warn_thr[l][c]   = {cfg_q[l][c][HI_THR_W-1:0], low_q[l][c]};
            warn_hyst[l][c]  = cfg_q[l][c][HYST_W+1:2];
            warn_en[l][c]    = cfg_q[l][c][6];
            warn_thrtl[l][c] = cfg_q[l][c][7];
         end
      end
   end

   always_comb begin
      for (int l = 0; l < LVL_NUM; l++) begin
         for (int c = 0; c < NUM_CH; c++) begin
            pend_clr[l][c] = reg_we
                          && (reg_addr == ((l == LVL_CRIT) ? A_PEND_CRIT : A_PEND_WARN))
                          && reg_wdata[flag_slot(l, c)];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         low_q  <= '0;
         crit_q <= '0;
         msk_q  <= '0;
         for (int l = 0; l < WARN_NUM; l++) msk_q[l] <= '1;
         pend_q <= '0;
         gate_q <= 1'b0;
      end else begin
         if (reg_we) begin
            for (int l = 0; l < WARN_NUM; l++) begin
               for (int c = 0; c < NUM_CH; c++) begin
                  if (reg_addr == warn_cfg_addr(l, c))         cfg_q[l][c] <= reg_wdata;
                  if (reg_addr == warn_cfg_addr(l, c) + 8'd1)  low_q[l][c] <= reg_wdata;
               end
            end
            for (int c = 0; c < NUM_CH; c++) begin
               if (reg_addr == A_CRIT_BASE + 8'(c)) crit_q[c] <= reg_wdata;
               if (reg_addr == A_MASK_WARN) begin
                  msk_q[0][c] <= reg_wdata[flag_slot(0, c)];
                  msk_q[1][c] <= reg_wdata[flag_slot(1, c)];
               end
               if (reg_addr == A_MASK_CRIT) msk_q[LVL_CRIT][c] <= reg_wdata[c];
            end
            if (reg_addr == A_GATE) gate_q <= reg_wdata[0];
         end
         // a fresh event outranks an acknowledge in the same cycle
         for (int l = 0; l < LVL_NUM; l++) begin
            for (int c = 0; c < NUM_CH; c++) begin
               if (evt[l][c])           pend_q[l][c] <= 1'b1;
               else if (pend_clr[l][c]) pend_q[l][c] <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_PEND_WARN: for (int c = 0; c < NUM_CH; c++) begin
            reg_rdata[flag_slot(0, c)] = pend_q[0][c];
            reg_rdata[flag_slot(1, c)] = pend_q[1][c];
         end
         A_PEND_CRIT: for (int c = 0; c < NUM_CH; c++) reg_rdata[c] = pend_q[LVL_CRIT][c];
         A_MASK_WARN: for (int c = 0; c < NUM_CH; c++) begin
            reg_rdata[flag_slot(0, c)] = msk_q[0][c];
            reg_rdata[flag_slot(1, c)] = msk_q[1][c];
         end
         A_MASK_CRIT: for (int c = 0; c < NUM_CH; c++) reg_rdata[c] = msk_q[LVL_CRIT][c];
         A_GATE:      reg_rdata[0] = gate_q;
         default:     ;
      endcase
      for (int l = 0; l < LVL_NUM; l++) begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (reg_addr == A_STAT_BASE + 8'(l)) reg_rdata[c] = hot[l][c];
         end
      end
      for (int l = 0; l < WARN_NUM; l++) begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (reg_addr == warn_cfg_addr(l, c))        reg_rdata = cfg_q[l][c];
            if (reg_addr == warn_cfg_addr(l, c) + 8'd1) reg_rdata = low_q[l][c];
         end
      end
      for (int c = 0; c < NUM_CH; c++) begin
         if (reg_addr == A_CRIT_BASE + 8'(c)) reg_rdata = crit_q[c];
      end
   end

   assign crit_thr = crit_q;
   assign pend     = pend_q;
   assign gate     = gate_q;
   assign irq_out  = (|(pend_q & ~msk_q)) & ~gate_q;
endmodule

// File: rtl/thermal_watch.sv
module thermal_watch
   import thw_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CODE_W = 10,
   parameter int unsigned HYST_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sample_valid,
   input  logic [NUM_CH*CODE_W-1:0] sample_codes,
   input  logic                     crit_mode,
   input  logic                     reg_we,
   input  logic [7:0]               reg_addr,
   input  logic [7:0]               reg_wdata,
   output logic [7:0]               reg_rdata,
   output logic                     irq_out,
   output logic [NUM_CH-1:0]        hot_throttle
);
   localparam int unsigned PAD_W = CODE_W - 8;

   generate
      if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
         $error("thermal_watch: NUM_CH must be 1..4");
      end
      if (CODE_W != 10) begin : g_bad_code
         $error("thermal_watch: CODE_W must be 10 for the byte register layout");
      end
      if (HYST_W != 4) begin : g_bad_hyst
         $error("thermal_watch: HYST_W must be 4");
      end
   endgenerate

   logic [WARN_NUM-1:0][NUM_CH-1:0][CODE_W-1:0] warn_thr;
   logic [WARN_NUM-1:0][NUM_CH-1:0][HYST_W-1:0] warn_hyst;
   logic [WARN_NUM-1:0][NUM_CH-1:0]             warn_en, warn_thrtl;
   logic [NUM_CH-1:0][7:0]                      crit_thr;
   logic [LVL_NUM-1:0][NUM_CH-1:0]              hot_lv, evt_lv, pend_lv;
   logic                                        gate;

   thw_regs #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .HYST_W(HYST_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .evt(evt_lv), .hot(hot_lv), .reg_rdata(reg_rdata),
      .warn_thr(warn_thr), .warn_hyst(warn_hyst), .warn_en(warn_en),
      .warn_thrtl(warn_thrtl), .crit_thr(crit_thr), .pend(pend_lv),
      .gate(gate), .irq_out(irq_out)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic [CODE_W-1:0] code, crit_wide;
         assign code = sample_codes[c*CODE_W +: CODE_W];

         for (genvar l = 0; l < WARN_NUM; l++) begin : g_warn
            thw_det #(.CODE_W(CODE_W), .HYST_W(HYST_W), .BOTH_DIR(1'b1)) u_det (
               .clk(clk), .rst_n(rst_n), .smp_valid(sample_valid),
               .enable(warn_en[l][c]), .code(code), .thr(warn_thr[l][c]),
               .hyst(warn_hyst[l][c]), .hot(hot_lv[l][c]), .evt(evt_lv[l][c])
            );
         end

         // critical byte scaled to code units per crit_mode
         assign crit_wide = crit_mode ? {crit_thr[c], {PAD_W{1'b0}}}
                                      : {1'b0, crit_thr[c], {(PAD_W-1){1'b0}}};

         thw_det #(.CODE_W(CODE_W), .HYST_W(HYST_W), .BOTH_DIR(1'b0)) u_crit (
            .clk(clk), .rst_n(rst_n), .smp_valid(sample_valid), .enable(1'b1),
            .code(code), .thr(crit_wide), .hyst('0),
            .hot(hot_lv[LVL_CRIT][c]), .evt(evt_lv[LVL_CRIT][c])
         );

         assign hot_throttle[c] = (hot_lv[0][c] & warn_thrtl[0][c])
                                | (hot_lv[1][c] & warn_thrtl[1][c]);
      end
   endgenerate
endmodule

// File: rtl/thw_checker.sv
module thw_checker #(
   parameter int unsigned NUM_CH = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   sample_valid,
   input logic                   irq_out,
   input logic                   gate,
   input logic [7:0]             reg_addr,
   input logic [7:0]             reg_rdata,
   input logic [NUM_CH-1:0]      hot_throttle,
   input logic [2:0][NUM_CH-1:0] hot_lv,
   input logic [2:0][NUM_CH-1:0] pend_lv
);
   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !irq_out);

   assert_lvl0_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((hot_lv[0] ^ $past(hot_lv[0])) & ~pend_lv[0]) == '0);

   assert_lvl1_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((hot_lv[1] ^ $past(hot_lv[1])) & ~pend_lv[1]) == '0);

   assert_crit_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_lv[2] & ~$past(hot_lv[2]) & ~pend_lv[2]) == '0);

   assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 8'h01) |-> (reg_rdata[7:4] == 4'h0));

   assert_gate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      gate |-> !irq_out);

   assert_throttle_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_throttle & ~(hot_lv[0] | hot_lv[1])) == '0);

   assert_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_valid |=> $stable(hot_lv));
endmodule

bind thermal_watch thw_checker #(.NUM_CH(NUM_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .irq_out(irq_out),
   .gate(gate), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
   .hot_throttle(hot_throttle), .hot_lv(hot_lv), .pend_lv(pend_lv)
);

// File: tb/thermal_watch_tb.sv
module thermal_watch_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_valid = 1'b0;
   logic [39:0] sample_codes;
   logic        crit_mode = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic        irq_out;
   logic [3:0]  hot_throttle;

   logic [9:0]  cur [4];
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   thermal_watch dut_i (
      .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
      .sample_codes(sample_codes), .crit_mode(crit_mode), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_out(irq_out), .hot_throttle(hot_throttle)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic drive_codes();
      for (int c = 0; c < 4; c++) sample_codes[c*10 +: 10] = cur[c];
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic samp();
      @(negedge clk);
      drive_codes();
      sample_valid = 1'b1;
      @(negedge clk);
      sample_valid = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(8'h00, d); chk("R1", "warn pending", d, 8'h00);
      rd(8'h01, d); chk("R1", "crit pending", d, 8'h00);
      rd(8'h02, d); chk("R1", "warn mask", d, 8'hFF);
      rd(8'h03, d); chk("R1", "crit mask", d, 8'h00);
      rd(8'h04, d); chk("R1", "gate", d, 8'h00);
      rd(8'h05, d); chk("R1", "status lvl0", d, 8'h00);
      rd(8'h07, d); chk("R1", "status lvl2", d, 8'h00);
      chk("R1", "irq", irq_out, 1'b0);
   endtask

   task automatic t_regs();
      logic [7:0] d;
      wr(8'h14, 8'hBE); wr(8'h15, 8'h5A); wr(8'h21, 8'h33);
      rd(8'h14, d); chk("R2", "ch1 lvl0 config", d, 8'hBE);
      rd(8'h15, d); chk("R2", "ch1 lvl0 low", d, 8'h5A);
      rd(8'h21, d); chk("R2", "ch1 crit", d, 8'h33);
   endtask

   task automatic t_trip();
      logic [7:0] d;
      wr(8'h10, 8'h51); wr(8'h11, 8'h80);   // ch0 lvl0: thr 384, hyst 4, enabled
      wr(8'h1A, 8'h42); wr(8'h1B, 8'h00);   // ch2 lvl1: thr 512, hyst 0, enabled
      wr(8'h02, 8'hFE);
      samp();
      rd(8'h00, d); chk("R3", "no event above thr", d, 8'h00);
      cur[0] = 10'd384; cur[1] = 10'd300; cur[2] = 10'd512;
      samp();
      rd(8'h00, d); chk("R3", "pending at thr", d, 8'h41);
      rd(8'h05, d); chk("R5", "lvl0 status, ch1 disabled", d, 8'h01);
      rd(8'h06, d); chk("R3", "lvl1 status", d, 8'h04);
      rd(8'h01, d); chk("R6", "no crit event", d, 8'h00);
      chk("R8", "irq unmasked bit", irq_out, 1'b1);
      chk("R9", "no throttle", hot_throttle, 4'h0);
      wr(8'h00, 8'h01);
      rd(8'h00, d); chk("R7", "partial clear", d, 8'h40);
      chk("R8", "masked pending quiet", irq_out, 1'b0);
      wr(8'h02, 8'h00);
      chk("R8", "unmasked pending", irq_out, 1'b1);
      wr(8'h04, 8'h01);
      chk("R8", "gate blocks", irq_out, 1'b0);
      wr(8'h04, 8'h00);
      wr(8'h00, 8'h40);
      rd(8'h00, d); chk("R7", "cleared", d, 8'h00);
   endtask

   task automatic t_hyst();
      logic [7:0] d;
      cur[0] = 10'd388; samp();
      rd(8'h00, d); chk("R4", "inside band no event", d, 8'h00);
      rd(8'h05, d); chk("R4", "inside band still hot", d, 8'h01);
      cur[0] = 10'd389; samp();
      rd(8'h00, d); chk("R4", "release event", d, 8'h01);
      rd(8'h05, d); chk("R4", "status cold", d, 8'h00);
      wr(8'h00, 8'h01);
      @(negedge clk);
      cur[0] = 10'd100; drive_codes();
      repeat (3) @(negedge clk);
      rd(8'h05, d); chk("R10", "no strobe status", d, 8'h00);
      rd(8'h00, d); chk("R10", "no strobe pending", d, 8'h00);
      cur[0] = 10'h3FF; drive_codes();
   endtask

   task automatic t_crit();
      logic [7:0] d;
      wr(8'h23, 8'h40);
      cur[3] = 10'd200; samp();
      rd(8'h01, d); chk("R6", "mode0 200 above 128", d, 8'h00);
      cur[3] = 10'd128; samp();
      rd(8'h01, d); chk("R6", "mode0 trip at 128", d, 8'h08);
      rd(8'h07, d); chk("R6", "crit status", d, 8'h08);
      chk("R8", "crit irq", irq_out, 1'b1);
      wr(8'h01, 8'hFF);
      rd(8'h01, d); chk("R7", "crit clear, reserved zero", d, 8'h00);
      cur[3] = 10'd129; samp();
      rd(8'h07, d); chk("R6", "crit status cleared", d, 8'h00);
      rd(8'h01, d); chk("R6", "no cold crit event", d, 8'h00);
      @(negedge clk); crit_mode = 1'b1;
      cur[3] = 10'd200; samp();
      rd(8'h01, d); chk("R6", "mode1 trip 200 under 256", d, 8'h08);
      wr(8'h01, 8'h08);
   endtask

   task automatic t_throttle();
      wr(8'h10, 8'hD1);
      cur[0] = 10'd300; samp();
      chk("R9", "throttle ch0", hot_throttle, 4'h1);
      cur[0] = 10'h3FF; samp();
      chk("R9", "throttle released", hot_throttle, 4'h0);
   endtask

   initial begin
      for (int c = 0; c < 4; c++) cur[c] = 10'h3FF;
      drive_codes();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_trip();
      t_hyst();
      t_crit();
      t_throttle();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule